// File: doc/BRIEF.md
# Address-Range Cache Operation Sequencer

This block turns one range command (a start byte address, a byte length and an operation code) into a series of per-block cache maintenance operations. It walks every cache block that the range touches, from the block holding the first byte to the block holding the last byte. It offers one block operation per cycle to a downstream cache-management port under a valid/ready handshake.

The upstream side accepts a command only while the sequencer is idle. A one-cycle done pulse marks the end of each command. A build parameter states whether the target cache exists. When it does not, every command is treated as a no-op: the command completes on the next cycle and no block operations are issued.

The five operations are:
- fetch-for-read and fetch-for-store, which bring the range into the cache;
- zero-fill, which writes zeros over the whole range;
- write-back, which stores the modified contents of each block;
- write-back-and-invalidate, which stores the modified contents of each block and then invalidates it.

The sequencer does not interpret these operations. It forwards the code unchanged with every block.

Top module: `rsq_top`

## Requirements
- R1: After reset, `busy`, `done` and `blk_valid` are 0 and `cmd_ready` is 1.
- R2: The first block address is `cmd_addr` rounded down to a multiple of BLOCK_BYTES (128). Each later block address is the previous one plus BLOCK_BYTES. The last block issued is the one containing `cmd_addr + cmd_len - 1`, so a short range that straddles a boundary yields two blocks.
- R3: A command with `cmd_len` = 0 issues no block operation, and `done` is 1 in the cycle after the command is accepted.
- R4: Every block operation carries the accepted command's `cmd_op` unchanged. The codes are 0 fetch-for-read, 1 fetch-for-store, 2 zero-fill, 3 write-back, 4 write-back-and-invalidate.
- R5: While `busy`, `blk_valid` is 1 and one block is accepted in each cycle in which `blk_ready` is 1. While `blk_ready` is 0, `blk_addr` and `blk_op` hold their values.
- R6: `cmd_ready` is 0 while `busy`. A command offered during that time is ignored: none of its blocks ever appear and the running walk is unchanged.
- R7: `done` is 1 for exactly the one cycle after the last block is accepted, and `busy` falls in that same cycle.
- R8: With HAS_CACHE = 0, every accepted command raises `done` in the next cycle, `busy` stays 0 and `blk_valid` is never 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Range command offered |
| cmd_ready | output | 1 | Sequencer idle; the command is taken when both are high |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Length in bytes |
| cmd_op | input | 3 | Operation code (see R4) |
| blk_valid | output | 1 | Block operation offered downstream |
| blk_ready | input | 1 | Downstream accepts the block operation |
| blk_addr | output | ADDR_W | Block-aligned address of the operation |
| blk_op | output | 3 | Operation code for this block |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
Several properties are checked on every cycle:
- a stalled block operation holds steady;
- consecutive accepted blocks are exactly one block apart;
- no command is taken while busy;
- the fall of `busy` always coincides with `done`;
- the no-cache build never goes busy.

Other behaviour can only be shown by the bench's scenarios, which compare against a queue of expected block addresses built from each command's range:
- that the walk starts and stops at the right blocks, including unaligned, straddling, zero-length and multi-block ranges;
- that each opcode is carried through;
- that a command offered while busy leaves no trace.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [2:0] {
    RSQ_FETCH_RD = 3'd0,
    RSQ_FETCH_WR = 3'd1,
    RSQ_ZERO     = 3'd2,
    RSQ_WB       = 3'd3,
    RSQ_WB_INV   = 3'd4
  } rsq_op_e;
endpackage

// File: rtl/rsq_span.sv
// Converts a byte range into first and last block indices.
module rsq_span #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int OFS_W  = 7,
  localparam int IDX_W = ADDR_W - OFS_W
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  len,
  output logic [IDX_W-1:0]  first_idx,
  output logic [IDX_W-1:0]  last_idx,
  output logic              empty
);
  logic [ADDR_W-1:0] end_addr;

  always_comb begin
    end_addr  = start_addr + ADDR_W'(len) - ADDR_W'(1);
    first_idx = IDX_W'(start_addr >> OFS_W);
    last_idx  = IDX_W'(end_addr >> OFS_W);
    empty     = (len == '0);
  end
endmodule

// File: rtl/rsq_walker.sv
// Walk state machine: holds the current block and issues one block per handshake.
module rsq_walker
  import rsq_pkg::*;
#(
  parameter int IDX_W     = 25,
  parameter int HAS_CACHE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             empty,
  input  logic [IDX_W-1:0] first_idx,
  input  logic [IDX_W-1:0] last_idx,
  input  rsq_op_e          op_in,
  input  logic             blk_ready,
  output logic             blk_valid,
  output logic [IDX_W-1:0] blk_idx,
  output rsq_op_e          blk_op,
  output logic             busy,
  output logic             done
);
  localparam bit PRESENT = (HAS_CACHE != 0);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] cur_q, cur_d;
  logic [IDX_W-1:0] last_q, last_d;
  rsq_op_e          op_q, op_d;
  logic             fire, at_last, ld_en, adv_en;

  // Next-state logic
  always_comb begin
    fire    = busy_q & blk_ready;
    at_last = (cur_q == last_q);
    ld_en   = acc & ~empty & PRESENT;
    adv_en  = fire & ~at_last;
    busy_d  = busy_q;
    cur_d   = cur_q;
    last_d  = last_q;
    op_d    = op_q;
    done_d  = 1'b0;
    if (acc) begin
      if (ld_en) begin
        busy_d = 1'b1;
        cur_d  = first_idx;
        last_d = last_idx;
        op_d   = op_in;
      end else begin
        done_d = 1'b1;
      end
    end else if (fire) begin
      if (at_last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cur_d = cur_q + IDX_W'(1);
      end
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      last_q <= '0;
      op_q   <= RSQ_FETCH_RD;
    end else begin
      if (ld_en | adv_en) cur_q <= cur_d;
      if (ld_en) begin
        last_q <= last_d;
        op_q   <= op_d;
      end
    end
  end

  assign blk_valid = busy_q;
  assign blk_idx   = cur_q;
  assign blk_op    = op_q;
  assign busy      = busy_q;
  assign done      = done_q;

  // R5: a stalled offer keeps its address and opcode
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_ready) |=> (blk_valid && $stable(blk_idx) && $stable(blk_op)));

  // R2: after an accepted block, any following offer is the next block
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_ready) |=> (!blk_valid || blk_idx == IDX_W'($past(blk_idx) + 1'b1)));

  // R6: nothing is accepted while a walk is running
  a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !acc);

  // R7: the walk ends together with the done pulse
  a_r7_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  generate
    if (!PRESENT) begin : gen_nop_chk
      // R8: without a cache the sequencer never walks
      a_r8_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q && !blk_valid);
    end
  endgenerate
endmodule

// File: rtl/rsq_top.sv
module rsq_top
  import rsq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BLOCK_BYTES = 128,
  parameter int HAS_CACHE   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [2:0]        cmd_op,
  output logic              blk_valid,
  input  logic              blk_ready,
  output logic [ADDR_W-1:0] blk_addr,
  output logic [2:0]        blk_op,
  output logic              busy,
  output logic              done
);
  localparam int OFS_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = ADDR_W - OFS_W;

  logic             acc, empty;
  logic [IDX_W-1:0] first_idx, last_idx, blk_idx;
  rsq_op_e          op_out;

  assign cmd_ready = ~busy;
  assign acc       = cmd_valid & cmd_ready;

  rsq_span #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFS_W(OFS_W)) u_span (
    .start_addr (cmd_addr),
    .len        (cmd_len),
    .first_idx  (first_idx),
    .last_idx   (last_idx),
    .empty      (empty)
  );

  rsq_walker #(.IDX_W(IDX_W), .HAS_CACHE(HAS_CACHE)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .empty     (empty),
    .first_idx (first_idx),
    .last_idx  (last_idx),
    .op_in     (rsq_op_e'(cmd_op)),
    .blk_ready (blk_ready),
    .blk_valid (blk_valid),
    .blk_idx   (blk_idx),
    .blk_op    (op_out),
    .busy      (busy),
    .done      (done)
  );

  assign blk_addr = {blk_idx, {OFS_W{1'b0}}};
  assign blk_op   = op_out;
endmodule

// File: tb/rsq_top_bench.sv
module rsq_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [15:0] cmd_len = '0;
  logic [2:0]  cmd_op = '0;
  logic        blk_ready = 1'b1;
  logic        cmd_ready, blk_valid, busy, done;
  logic [31:0] blk_addr;
  logic [2:0]  blk_op;
  logic        nc_cmd_ready, nc_blk_valid, nc_busy, nc_done;
  logic [31:0] nc_blk_addr;
  logic [2:0]  nc_blk_op;

  int compared = 0;
  int mismatched = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 0;

  always #5 clk = ~clk;

  rsq_top u_rsq_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_op(cmd_op),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_addr(blk_addr),
    .blk_op(blk_op), .busy(busy), .done(done));

  rsq_top #(.HAS_CACHE(0)) u_nocache (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(nc_cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_op(cmd_op),
    .blk_valid(nc_blk_valid), .blk_ready(blk_ready), .blk_addr(nc_blk_addr),
    .blk_op(nc_blk_op), .busy(nc_busy), .done(nc_done));

  // Behavioural reference model
  logic [31:0] mq[$];
  int  m_op = 0;
  bit  m_busy = 0, m_done = 0, m_nc_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_busy = 0; m_done = 0; m_nc_done = 0;
    end else begin
      m_done = 0;
      m_nc_done = cmd_valid;
      if (m_busy) begin
        if (blk_ready) begin
          void'(mq.pop_front());
          if (mq.size() == 0) begin m_busy = 0; m_done = 1; end
        end
      end else if (cmd_valid) begin
        if (cmd_len == 0) m_done = 1;
        else begin
          logic [31:0] a, last;
          a    = cmd_addr & ~32'd127;
          last = (cmd_addr + {16'd0, cmd_len} - 32'd1) & ~32'd127;
          forever begin
            mq.push_back(a);
            if (a == last) break;
            a = a + 32'd128;
          end
          m_op = cmd_op;
          m_busy = 1;
        end
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the clock edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R6", "cmd_ready", cmd_ready, !m_busy);
      chk("R6", "busy", busy, m_busy);
      chk("R5", "blk_valid", blk_valid, m_busy);
      chk("R7", "done", done, m_done);
      if (m_busy) begin
        chk("R2", "blk_addr", blk_addr, mq[0]);
        chk("R4", "blk_op", blk_op, m_op);
      end
      chk("R8", "nc_done", nc_done, m_nc_done);
      chk("R8", "nc_blk_valid", nc_blk_valid, 0);
      chk("R8", "nc_busy", nc_busy, 0);
    end
  end

  // Downstream ready pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (ready_mode == 0) blk_ready <= 1'b1;
    else blk_ready <= lfsr[0] | lfsr[3];
  end

  task automatic send(input logic [31:0] a, input logic [15:0] l, input logic [2:0] op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_len = l; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "blk_valid", blk_valid, 0);
    chk("R1", "cmd_ready", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R2/R4: aligned single block, then straddling two-byte range
    send(32'h0000_1000, 16'd128, 3'd0); wait_idle();
    send(32'h0000_017F, 16'd2, 3'd1);   wait_idle();
    // R3: zero length
    send(32'h0000_2345, 16'd0, 3'd2);   wait_idle();
    // R2: unaligned multi-block range, every opcode (R4)
    for (int op = 0; op < 5; op++) begin
      send(32'h0001_0033 + op * 32'h40, 16'd1000, op[2:0]); wait_idle();
    end
    // R5: stalls from downstream
    ready_mode = 1;
    send(32'h0002_0010, 16'd700, 3'd3); wait_idle();
    send(32'h0002_0000, 16'd1, 3'd4);   wait_idle();
    ready_mode = 0;
    // R6: command offered while busy is ignored
    send(32'h0003_0000, 16'd1024, 3'd3);
    cmd_valid = 1'b1; cmd_addr = 32'h0009_0000; cmd_len = 16'd128; cmd_op = 3'd2;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    // R7/R3: back-to-back commands, zero-length right after a walk
    send(32'h0004_0080, 16'd256, 3'd0);
    wait_idle();
    send(32'h0004_1000, 16'd0, 3'd1);
    send(32'h0004_2000, 16'd129, 3'd2); wait_idle();
    // R8: the no-cache instance has seen every command above
    repeat (5) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1;
    summary();
    $finish;
  end
endmodule